// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces operand addresses for a DSP datapath. It holds four pointer registers, four modify registers and a length register for each pointer. An access names one pointer and, on its own, one modify register. The address presented is the pointer as it stood before the access. The pointer is then stepped by the signed modify value.

With a nonzero length, the pointer stays inside a circular buffer of that length and wraps at either end. With a length of zero, the pointer steps linearly and wraps at the top of the 14-bit address space. A processor places two instances side by side, one feeding data memory and one feeding program memory, so that both operands are fetched in the same cycle.

A single write port loads pointers, modify values and lengths. A load to a pointer in the same cycle as an access to that pointer takes precedence over the access.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, every pointer, modify and length register and `addr_o` read zero.
- R2: A write with `wr_kind_i` = 0 loads pointer `wr_sel_i`, 1 loads modify register `wr_sel_i`, and 2 loads length `wr_sel_i`. Code 3 changes no register.
- R3: One cycle after a clock edge with `acc_en_i` high, `addr_o` shows the selected pointer's value from before that edge. Without an access, `addr_o` holds its value.
- R4: An access updates the selected pointer by the modify register named by `acc_mod_i`, read as signed two's complement. Any modify register can be paired with any pointer.
- R5: With a length of zero, the updated pointer is (pointer + modify) modulo 2^14.
- R6: With a nonzero length L, the buffer base is the pointer rounded down to a multiple of the smallest power of two that is at least L. When the offset from the base is below L and |modify| < L, the new pointer is base + ((offset + modify) mod L).
- R7: A pointer load and an access to the same pointer in one cycle leave the loaded value in the pointer. `addr_o` still shows the old value.
- R8: An access leaves every pointer other than the selected one unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | 0 pointer, 1 modify, 2 length, 3 none |
| wr_sel_i | input | 2 | Register number for the write |
| wr_data_i | input | 14 | Write data |
| acc_en_i | input | 1 | Access strobe |
| acc_ptr_i | input | 2 | Pointer used by the access |
| acc_mod_i | input | 2 | Modify register used by the access |
| addr_o | output | 14 | Registered address (pre-update pointer) |

## Verification
The bench sweeps every modify value allowed for a set of lengths, including lengths that are not powers of two. It runs each buffer more than twice around, with buffers placed both low in memory and at its top end. A design that picked the wrong base would leave its buffer. A design that compared against the power-of-two block instead of the length would visit addresses past the end. A design that did its sum in the full address instead of the offset would break on the buffer at the top of memory.

Linear mode is checked across the 2^14 boundary in both directions. That catches a design that wraps with no length set. The bench also targets these cases:
- a pointer load colliding with an access, where a design that let the access win would drop the load;
- the unused write code, where a stray decode would corrupt a register;
- accesses to one pointer, where a shared update path would disturb its neighbours.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    WK_PTR  = 2'd0,
    WK_MOD  = 2'd1,
    WK_LEN  = 2'd2,
    WK_NONE = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/cag_regs.sv
module cag_regs #(
  parameter int unsigned AW    = 14,
  parameter int unsigned NPTR  = 4,
  parameter int unsigned NMOD  = 4,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned PW    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [1:0]                wr_kind_i,
  input  logic [SEL_W-1:0]          wr_sel_i,
  input  logic [AW-1:0]             wr_data_i,
  input  logic                      acc_en_i,
  input  logic [PW-1:0]             acc_ptr_i,
  input  logic [AW-1:0]             nxt_i,
  output logic [NPTR-1:0][AW-1:0]   ptr_o,
  output logic [NMOD-1:0][AW-1:0]   mod_o,
  output logic [NPTR-1:0][AW-1:0]   len_o
);
  import cag_pkg::*;

  logic wr_ptr, wr_mod, wr_len;
  assign wr_ptr = wr_en_i && (wr_kind_i == WK_PTR);
  assign wr_mod = wr_en_i && (wr_kind_i == WK_MOD);
  assign wr_len = wr_en_i && (wr_kind_i == WK_LEN);

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    // load beats post-modify on a same-cycle collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_o[i] <= '0;
      end else if (wr_ptr && wr_sel_i == SEL_W'(i)) begin
        ptr_o[i] <= wr_data_i;
      end else if (acc_en_i && acc_ptr_i == PW'(i)) begin
        ptr_o[i] <= nxt_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_o[i] <= '0;
      end else if (wr_len && wr_sel_i == SEL_W'(i)) begin
        len_o[i] <= wr_data_i;
      end
    end
  end

  for (genvar j = 0; j < NMOD; j++) begin : g_mod
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mod_o[j] <= '0;
      end else if (wr_mod && wr_sel_i == SEL_W'(j)) begin
        mod_o[j] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/cag_next.sv
module cag_next #(
  parameter int unsigned AW = 14
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0]        msk, base, off, lin, circ;
  logic signed [AW+1:0] soff, slen, sadj;

  always_comb begin
    // smallest 2^k - 1 covering len-1
    msk = len_i - AW'(1);
    for (int s = 1; s < int'(AW); s = s * 2) msk = msk | (msk >> s);
    base = ptr_i & ~msk;
    off  = ptr_i & msk;
    soff = $signed({2'b00, off}) + $signed({{2{mod_i[AW-1]}}, mod_i});
    slen = $signed({2'b00, len_i});
    if (soff >= slen)     sadj = soff - slen;
    else if (soff[AW+1])  sadj = soff + slen;
    else                  sadj = soff;
    circ  = base + sadj[AW-1:0];
    lin   = ptr_i + mod_i;
    nxt_o = (len_i == '0) ? lin : circ;
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int unsigned AW   = 14,
  parameter int unsigned NPTR = 4,
  parameter int unsigned NMOD = 4,
  localparam int unsigned PW    = $clog2(NPTR),
  localparam int unsigned MW    = $clog2(NMOD),
  localparam int unsigned SEL_W = (PW > MW) ? PW : MW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_kind_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             acc_en_i,
  input  logic [PW-1:0]    acc_ptr_i,
  input  logic [MW-1:0]    acc_mod_i,
  output logic [AW-1:0]    addr_o
);
  logic [NPTR-1:0][AW-1:0] ptr_q;
  logic [NMOD-1:0][AW-1:0] mod_q;
  logic [NPTR-1:0][AW-1:0] len_q;
  logic [AW-1:0]           cur_ptr, cur_mod, cur_len, nxt_ptr, addr_q;

  cag_regs #(
    .AW(AW), .NPTR(NPTR), .NMOD(NMOD), .SEL_W(SEL_W), .PW(PW)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (wr_kind_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .acc_en_i  (acc_en_i),
    .acc_ptr_i (acc_ptr_i),
    .nxt_i     (nxt_ptr),
    .ptr_o     (ptr_q),
    .mod_o     (mod_q),
    .len_o     (len_q)
  );

  assign cur_ptr = ptr_q[acc_ptr_i];
  assign cur_len = len_q[acc_ptr_i];
  assign cur_mod = mod_q[acc_mod_i];

  cag_next #(.AW(AW)) u_next (
    .ptr_i (cur_ptr),
    .mod_i (cur_mod),
    .len_i (cur_len),
    .nxt_o (nxt_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (acc_en_i) addr_q <= cur_ptr;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int unsigned AW    = 14,
  parameter int unsigned NPTR  = 4,
  parameter int unsigned NMOD  = 4,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned PW    = 2,
  parameter int unsigned MW    = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [1:0]              wr_kind_i,
  input logic [SEL_W-1:0]        wr_sel_i,
  input logic [AW-1:0]           wr_data_i,
  input logic                    acc_en_i,
  input logic [PW-1:0]           acc_ptr_i,
  input logic [MW-1:0]           acc_mod_i,
  input logic [AW-1:0]           addr_o,
  input logic [NPTR-1:0][AW-1:0] ptr_i,
  input logic [NMOD-1:0][AW-1:0] mod_i,
  input logic [NPTR-1:0][AW-1:0] len_i
);
  logic [NPTR-1:0] in_buf;
  logic [AW-1:0]   mv, mabs;
  logic            touch, small_mod, ld_hit;

  for (genvar i = 0; i < NPTR; i++) begin : g_buf
    logic [AW-1:0] msk;
    always_comb begin
      msk = len_i[i] - AW'(1);
      for (int s = 1; s < int'(AW); s = s * 2) msk = msk | (msk >> s);
      in_buf[i] = (len_i[i] == '0) || ((ptr_i[i] & msk) < len_i[i]);
    end

    // R8: untouched pointers keep their value
    a_r8_others_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(acc_en_i && acc_ptr_i == PW'(i)) &&
       !(wr_en_i && wr_kind_i == 2'd0 && wr_sel_i == SEL_W'(i)))
      |=> $stable(ptr_i[i]));
  end

  always_comb begin
    mv        = mod_i[acc_mod_i];
    mabs      = mv[AW-1] ? (~mv + AW'(1)) : mv;
    small_mod = mabs < len_i[acc_ptr_i];
    touch     = wr_en_i && (wr_kind_i == 2'd0 || wr_kind_i == 2'd2) &&
                (wr_sel_i == SEL_W'(acc_ptr_i));
    ld_hit    = wr_en_i && wr_kind_i == 2'd0 && (wr_sel_i == SEL_W'(acc_ptr_i));
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_addr: assert (addr_o == '0);
  end

  a_r3_post_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> addr_o == $past(ptr_i[acc_ptr_i]));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_en_i |=> $stable(addr_o));

  a_r5_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && len_i[acc_ptr_i] == '0 && !touch)
    |=> ptr_i[$past(acc_ptr_i)] == AW'($past(ptr_i[acc_ptr_i]) + $past(mod_i[acc_mod_i])));

  a_r6_in_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && len_i[acc_ptr_i] != '0 && in_buf[acc_ptr_i] && small_mod && !touch)
    |=> in_buf[$past(acc_ptr_i)]);

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && ld_hit) |=> ptr_i[$past(acc_ptr_i)] == $past(wr_data_i));
endmodule

bind circ_addr_gen cag_checker #(
  .AW(AW), .NPTR(NPTR), .NMOD(NMOD), .SEL_W(SEL_W), .PW(PW), .MW(MW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_kind_i (wr_kind_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .acc_en_i  (acc_en_i),
  .acc_ptr_i (acc_ptr_i),
  .acc_mod_i (acc_mod_i),
  .addr_o    (addr_o),
  .ptr_i     (ptr_q),
  .mod_i     (mod_q),
  .len_i     (len_q)
);

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;
  localparam int AW  = 14;
  localparam int MEM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_kind = '0;
  logic [1:0]    wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic          acc_en = 1'b0;
  logic [1:0]    acc_ptr = '0;
  logic [1:0]    acc_mod = '0;
  logic [AW-1:0] addr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  circ_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .acc_en_i(acc_en),
    .acc_ptr_i(acc_ptr), .acc_mod_i(acc_mod), .addr_o(addr)
  );

  task automatic check(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_sel = 2'(sel); wr_data = AW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // access, then sample the registered address at the next falling edge
  task automatic acc(input int p, input int q, input string r, input int exp);
    @(negedge clk);
    acc_en = 1'b1; acc_ptr = 2'(p); acc_mod = 2'(q);
    @(negedge clk);
    acc_en = 1'b0;
    check(r, int'(addr), exp);
  endtask

  function automatic int wrapm(input int v, input int m);
    return ((v % m) + m) % m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lens [8] = '{1, 2, 3, 5, 7, 8, 12, 16};
    int lmods[6] = '{-5, -1, 0, 1, 7, 4000};
    repeat (3) @(negedge clk);
    check("R1", int'(addr), 0);
    rst_n = 1'b1;

    // R1: all pointers and modifies zero
    for (int p = 0; p < 4; p++) begin
      acc(p, p, "R1", 0);
      acc(p, 3 - p, "R1", 0);
    end

    // R2: code 3 writes nothing
    wr(3, 0, 5);
    acc(0, 0, "R2", 0);
    acc(0, 0, "R2", 0);

    // R8 isolation, R2 loads, R4 pairing
    wr(0, 0, 10);
    wr(0, 1, 20);
    wr(1, 1, 3);
    for (int k = 0; k < 5; k++) acc(1, 1, "R8", 20 + 3 * k);
    acc(0, 0, "R8", 10);
    acc(1, 0, "R3", 35);
    acc(1, 0, "R3", 35);

    // R7: load and access collide on pointer 2
    wr(0, 2, 77);
    wr(1, 3, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'd0; wr_sel = 2'd2; wr_data = AW'(500);
    acc_en = 1'b1; acc_ptr = 2'd2; acc_mod = 2'd1;
    @(negedge clk);
    wr_en = 1'b0; acc_en = 1'b0;
    check("R7", int'(addr), 77);
    acc(2, 3, "R7", 500);
    acc(2, 3, "R7", 500);

    // R5: linear mode across both ends of memory
    foreach (lmods[mi]) begin
      int cur;
      cur = (mi % 2 == 0) ? MEM - 6 : 4;
      wr(2, mi % 4, 0);
      wr(1, (mi + 1) % 4, wrapm(lmods[mi], MEM));
      wr(0, mi % 4, cur);
      for (int k = 0; k < 8; k++) begin
        acc(mi % 4, (mi + 1) % 4, "R5", cur);
        cur = wrapm(cur + lmods[mi], MEM);
      end
    end

    // R6/R4: circular sweep over every legal modify
    foreach (lens[li]) begin
      int len, pw;
      len = lens[li];
      pw = 1;
      while (pw < len) pw = pw * 2;
      for (int m = -(len - 1); m <= len - 1; m++) begin
        for (int blk = 0; blk < 2; blk++) begin
          int p, q, start, base, off;
          p = li % 4;
          q = (li + m + 20) % 4;
          start = (blk == 0) ? 3 * pw : MEM - pw;
          start = start + wrapm(m + li, len);
          base = start - (start % pw);
          off = start % pw;
          wr(2, p, len);
          wr(1, q, wrapm(m, MEM));
          wr(0, p, start);
          for (int k = 0; k < 2 * len + 2; k++) begin
            acc(p, q, "R6", base + off);
            off = wrapm(off + m, len);
          end
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule